// File: doc/BRIEF.md
# Carrier Wipe-off and Epoch Integrator

This block is the carrier-removal and correlation-accumulation stage of a single satellite-tracking channel. A phase-accumulator oscillator runs at a frequency set by a 32-bit tuning word. A coarse eight-step table turns the top three phase bits into a local cosine and sine. Each 2-bit IF sample is multiplied by both carriers to form an in-phase and a quadrature arm. Each arm is then multiplied by the local spreading-code chip and summed over one code epoch.

An epoch strobe closes the current integration window. The two sums move to holding registers, a one-cycle valid pulse flags them, and the accumulators restart with the product of the sample that arrives with the strobe. No sample is lost at the boundary. A force input makes the code multiplier +1, which isolates the carrier path: the dumped I/Q then carry only the beat between the input carrier and the local oscillator. At a sample rate near 5.714 MHz the 32-bit word gives a step of about 1.3 mHz, so an IF near 1.405 MHz can be tuned with a 100 Hz offset.

A small controller keeps the integration aligned to epochs. It has two states. `ST_FILL` is entered at reset. In it the samples are not summed and no dump is produced. The transition `T_ALIGN` moves it to `ST_TRACK` on the first epoch strobe. In `ST_TRACK`, the transition `T_DUMP` (strobe present) dumps and restarts the sums while staying in `ST_TRACK`. The transition `T_HOLD` (no strobe) keeps summing.

Top module: `carrier_wipeoff_accum`

## Requirements
- R1: While reset is asserted and after it is released, `dump_i`, `dump_q` and `dump_valid` are 0, the oscillator phase is 0 and the controller is in `ST_FILL`.
- R2: The oscillator phase advances by `freq_word` (modulo 2^32) once for each cycle with `sample_valid` high. Otherwise it holds. Each sample uses the phase as it stood before that sample's own advance.
- R3: A sample is decoded with bit 1 as the sign (1 = negative) and bit 0 as the magnitude (0 = 1, 1 = 3). The four codes 00, 01, 10 and 11 therefore mean +1, +3, -1 and -3.
- R4: The top three phase bits k select the carriers. The cosine for k = 0..7 is 2, 1, -1, -2, -2, -1, 1, 2. The sine for k = 0..7 is 1, 2, 2, 1, -1, -2, -2, -1.
- R5: The I product is sample × cosine × code and the Q product is sample × sine × code. Here `code_chip` = 1 means +1 and 0 means -1. Each product lies within ±6.
- R6: With `code_force` high, the code multiplier is +1 whatever `code_chip` holds.
- R7: In `ST_TRACK`, a cycle with `sample_valid` high and no epoch strobe adds the products to the accumulators. A cycle with `sample_valid` low leaves them unchanged.
- R8: An epoch strobe in `ST_TRACK` copies the accumulators, without the current sample, into `dump_i`/`dump_q` at that clock edge. It raises `dump_valid` for exactly the following cycle. In the same edge it loads the accumulators with the current product, or with 0 if `sample_valid` is low.
- R9: `dump_i` and `dump_q` hold their values between dumps.
- R10: In `ST_FILL`, samples are not summed and an epoch strobe produces no dump. The first strobe moves the controller to `ST_TRACK` and loads the accumulators as in R8. A reset during operation returns the controller to `ST_FILL`.
- R11: The accumulators are wide enough that an epoch of `EPOCH_MAX` full-scale products (±6) never wraps. The default `EPOCH_MAX` is 8192 samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_valid | input | 1 | A new IF sample is present |
| sample | input | 2 | IF sample, sign in bit 1, magnitude in bit 0 |
| code_chip | input | 1 | Local code chip, 1 = +1, 0 = -1 |
| code_force | input | 1 | Forces the code multiplier to +1 |
| epoch | input | 1 | Epoch strobe; the sample in this cycle opens the new window |
| freq_word | input | 32 | Oscillator phase increment per sample |
| dump_i | output | ACC_W (17) | Dumped in-phase sum, signed |
| dump_q | output | ACC_W (17) | Dumped quadrature sum, signed |
| dump_valid | output | 1 | One-cycle pulse with each new dump |

## Verification
Two functions can land in the same clock edge: the dump of a finished window and the loading of the first sample of the next window. The bench provokes this by raising the epoch strobe on every sample in the table sweep, so each dump must equal exactly the previous sample's product. It also places strobes on cycles without a sample, where the new window must start at zero. A behavioural model built from integers and real-valued trigonometry predicts the outputs and is compared every clock. This covers a long 100 Hz beat run and a full-scale epoch that stresses the accumulator width.

// File: rtl/cwa_pkg.sv
package cwa_pkg;

    typedef enum logic [0:0] {
        ST_FILL  = 1'b0,
        ST_TRACK = 1'b1
    } epoch_state_e;

    localparam int SAMPLE_W  = 2;
    localparam int CARRIER_W = 3;
    localparam int LEVEL_W   = 3;
    localparam int PROD_W    = 4;
    localparam int PROD_MAX  = 6;

    function automatic logic signed [LEVEL_W-1:0] decode_sample(input logic [SAMPLE_W-1:0] code);
        logic signed [LEVEL_W-1:0] mag;
        mag = code[0] ? 3'sd3 : 3'sd1;
        return code[1] ? -mag : mag;
    endfunction

endpackage

// File: rtl/cwa_nco.sv
module cwa_nco
    import cwa_pkg::*;
#(
    parameter int PHASE_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        step_en,
    input  logic [PHASE_W-1:0]          freq_word,
    output logic signed [CARRIER_W-1:0] cos_o,
    output logic signed [CARRIER_W-1:0] sin_o
);

    localparam int IDX_W = 3;

    logic [PHASE_W-1:0] phase_q;
    logic [IDX_W-1:0]   idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (step_en) begin
            phase_q <= phase_q + freq_word;
        end
    end

    assign idx = phase_q[PHASE_W-1 -: IDX_W];

    always_comb begin
        unique case (idx)
            3'd0: begin cos_o =  3'sd2; sin_o =  3'sd1; end
            3'd1: begin cos_o =  3'sd1; sin_o =  3'sd2; end
            3'd2: begin cos_o = -3'sd1; sin_o =  3'sd2; end
            3'd3: begin cos_o = -3'sd2; sin_o =  3'sd1; end
            3'd4: begin cos_o = -3'sd2; sin_o = -3'sd1; end
            3'd5: begin cos_o = -3'sd1; sin_o = -3'sd2; end
            3'd6: begin cos_o =  3'sd1; sin_o = -3'sd2; end
            3'd7: begin cos_o =  3'sd2; sin_o = -3'sd1; end
            default: begin cos_o = '0; sin_o = '0; end
        endcase
    end

    // R2: phase frozen on cycles without a sample
    assert_phase_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(phase_q));

endmodule

// File: rtl/cwa_mixer.sv
module cwa_mixer
    import cwa_pkg::*;
(
    input  logic [SAMPLE_W-1:0]         sample,
    input  logic                        code_chip,
    input  logic                        code_force,
    input  logic signed [CARRIER_W-1:0] cos_i,
    input  logic signed [CARRIER_W-1:0] sin_i,
    output logic signed [PROD_W-1:0]    prod_i,
    output logic signed [PROD_W-1:0]    prod_q
);

    logic signed [LEVEL_W-1:0]   level;
    logic                        code_neg;
    logic signed [CARRIER_W-1:0] carrier [2];
    logic signed [PROD_W-1:0]    prod    [2];

    assign level      = decode_sample(sample);
    assign code_neg   = !code_force && !code_chip;
    assign carrier[0] = cos_i;
    assign carrier[1] = sin_i;

    for (genvar a = 0; a < 2; a++) begin : g_arm
        logic signed [PROD_W+1:0] raw;
        assign raw     = (PROD_W+2)'(level) * (PROD_W+2)'(carrier[a]);
        assign prod[a] = code_neg ? -PROD_W'(raw) : PROD_W'(raw);
    end

    assign prod_i = prod[0];
    assign prod_q = prod[1];

endmodule

// File: rtl/cwa_epoch_ctrl.sv
module cwa_epoch_ctrl
    import cwa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sample_valid,
    input  logic epoch,
    output logic acc_add,
    output logic acc_load,
    output logic acc_dump,
    output logic dump_valid_o
);

    epoch_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL:  if (epoch) state_d = ST_TRACK;   // T_ALIGN
            ST_TRACK: state_d = ST_TRACK;               // T_DUMP / T_HOLD
            default:  state_d = ST_FILL;
        endcase
    end

    always_comb begin
        acc_add  = 1'b0;
        acc_load = 1'b0;
        acc_dump = 1'b0;
        unique case (state_q)
            ST_FILL: begin
                acc_load = epoch;
            end
            ST_TRACK: begin
                acc_load = epoch;
                acc_dump = epoch;
                acc_add  = sample_valid && !epoch;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dump_valid_o <= 1'b0;
        end else begin
            dump_valid_o <= acc_dump;
        end
    end

    // R10: no dump can leave the alignment state
    assert_fill_no_dump_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL) |=> !dump_valid_o);

endmodule

// File: rtl/cwa_arm_accum.sv
module cwa_arm_accum
    import cwa_pkg::*;
#(
    parameter int ACC_W = 17
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sample_valid,
    input  logic                     add,
    input  logic                     load,
    input  logic                     dump,
    input  logic signed [PROD_W-1:0] prod,
    output logic signed [ACC_W-1:0]  hold_o
);

    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W:0]   sum_wide;

    assign sum_wide = (ACC_W+1)'(acc_q) + (ACC_W+1)'(prod);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (load) begin
            acc_q <= sample_valid ? ACC_W'(prod) : '0;
        end else if (add) begin
            acc_q <= ACC_W'(sum_wide);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_o <= '0;
        end else if (dump) begin
            hold_o <= acc_q;
        end
    end

    // R11: adding never leaves the representable range
    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        add |-> (sum_wide[ACC_W] == sum_wide[ACC_W-1]));

    // R9: dump register only changes on a dump
    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !dump |=> $stable(hold_o));

    // R5: mixer products stay within the full-scale range
    assert_prod_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> (prod <= PROD_W'(PROD_MAX) && prod >= -PROD_W'(PROD_MAX)));

endmodule

// File: rtl/carrier_wipeoff_accum.sv
module carrier_wipeoff_accum
    import cwa_pkg::*;
#(
    parameter int PHASE_W   = 32,
    parameter int EPOCH_MAX = 8192,
    parameter int ACC_W     = $clog2(EPOCH_MAX * PROD_MAX + 1) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sample_valid,
    input  logic [SAMPLE_W-1:0]     sample,
    input  logic                    code_chip,
    input  logic                    code_force,
    input  logic                    epoch,
    input  logic [PHASE_W-1:0]      freq_word,
    output logic signed [ACC_W-1:0] dump_i,
    output logic signed [ACC_W-1:0] dump_q,
    output logic                    dump_valid
);

    logic signed [CARRIER_W-1:0] cos_w, sin_w;
    logic signed [PROD_W-1:0]    prod_w [2];
    logic signed [ACC_W-1:0]     hold_w [2];
    logic                        acc_add, acc_load, acc_dump;

    cwa_nco #(.PHASE_W(PHASE_W)) u_nco (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_en   (sample_valid),
        .freq_word (freq_word),
        .cos_o     (cos_w),
        .sin_o     (sin_w)
    );

    cwa_mixer u_mixer (
        .sample     (sample),
        .code_chip  (code_chip),
        .code_force (code_force),
        .cos_i      (cos_w),
        .sin_i      (sin_w),
        .prod_i     (prod_w[0]),
        .prod_q     (prod_w[1])
    );

    cwa_epoch_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_valid (sample_valid),
        .epoch        (epoch),
        .acc_add      (acc_add),
        .acc_load     (acc_load),
        .acc_dump     (acc_dump),
        .dump_valid_o (dump_valid)
    );

    for (genvar a = 0; a < 2; a++) begin : g_accum
        cwa_arm_accum #(.ACC_W(ACC_W)) u_arm (
            .clk          (clk),
            .rst_n        (rst_n),
            .sample_valid (sample_valid),
            .add          (acc_add),
            .load         (acc_load),
            .dump         (acc_dump),
            .prod         (prod_w[a]),
            .hold_o       (hold_w[a])
        );
    end

    assign dump_i = hold_w[0];
    assign dump_q = hold_w[1];

    // R8: a dump pulse never lasts past a cycle without a strobe
    assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dump_valid && !$past(epoch)) |-> 1'b0);

endmodule

// File: tb/carrier_wipeoff_accum_test.sv
module carrier_wipeoff_accum_test;

    localparam int ACC_W = 17;
    localparam real PI   = 3.14159265358979;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sample_valid = 1'b0;
    logic [1:0]       sample = 2'b00;
    logic             code_chip = 1'b0;
    logic             code_force = 1'b0;
    logic             epoch = 1'b0;
    logic [31:0]      freq_word = '0;
    logic signed [ACC_W-1:0] dump_i, dump_q;
    logic             dump_valid;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    // behavioural reference state
    logic [31:0] m_phase;
    int          m_acc_i, m_acc_q, m_di, m_dq;
    bit          m_valid, m_track;

    carrier_wipeoff_accum uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_valid (sample_valid),
        .sample       (sample),
        .code_chip    (code_chip),
        .code_force   (code_force),
        .epoch        (epoch),
        .freq_word    (freq_word),
        .dump_i       (dump_i),
        .dump_q       (dump_q),
        .dump_valid   (dump_valid)
    );

    always #4 clk = ~clk;

    function automatic int ref_cos(int k);
        return int'($floor(2.0 * $cos(2.0 * PI * (real'(k) + 0.5) / 8.0) + 0.5));
    endfunction

    function automatic int ref_sin(int k);
        return int'($floor(2.0 * $sin(2.0 * PI * (real'(k) + 0.5) / 8.0) + 0.5));
    endfunction

    task automatic model_reset();
        m_phase = '0; m_acc_i = 0; m_acc_q = 0; m_di = 0; m_dq = 0;
        m_valid = 1'b0; m_track = 1'b0;
    endtask

    task automatic compare(input string tag);
        checks++;
        if (int'(dump_i) != m_di || int'(dump_q) != m_dq || dump_valid != m_valid) begin
            failures++;
            $display("FAIL %s: got i=%0d q=%0d v=%0b expected i=%0d q=%0d v=%0b",
                     tag, dump_i, dump_q, dump_valid, m_di, m_dq, m_valid);
        end
    endtask

    task automatic step(input bit v, input logic [1:0] s, input bit chip, input bit frc,
                        input bit ep, input logic [31:0] fw, input string tag);
        int lvl, cs, k, pi_, pq;
        sample_valid = v; sample = s; code_chip = chip; code_force = frc;
        epoch = ep; freq_word = fw;
        @(posedge clk);
        lvl = (s[0] ? 3 : 1) * (s[1] ? -1 : 1);
        cs  = (frc || chip) ? 1 : -1;
        k   = int'(m_phase[31:29]);
        pi_ = lvl * ref_cos(k) * cs;
        pq  = lvl * ref_sin(k) * cs;
        m_valid = 1'b0;
        if (ep) begin
            if (m_track) begin
                m_di = m_acc_i; m_dq = m_acc_q; m_valid = 1'b1;
            end
            m_acc_i = v ? pi_ : 0;
            m_acc_q = v ? pq : 0;
            m_track = 1'b1;
        end else if (v && m_track) begin
            m_acc_i += pi_;
            m_acc_q += pq;
        end
        if (v) m_phase = m_phase + fw;
        @(negedge clk);
        compare(tag);
    endtask

    task automatic apply_reset(input string tag);
        @(negedge clk);
        rst_n = 1'b0;
        sample_valid = 1'b0; epoch = 1'b0;
        model_reset();
        @(negedge clk);
        compare(tag);
        @(negedge clk);
        rst_n = 1'b1;
        compare(tag);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            failures++;
            $display("FAIL watchdog: got cycles=%0d expected completion", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        real   fs, fin, ph;
        logic [31:0] fw_beat;
        model_reset();

        // R1: reset state
        apply_reset("R1 reset");

        // R10: samples before first strobe are discarded, first strobe gives no dump
        for (int n = 0; n < 5; n++) step(1, 2'b01, 1, 1, 0, 32'h0, "R10 fill");
        step(1, 2'b00, 1, 1, 1, 32'h0, "R10 align");
        step(0, 2'b00, 1, 1, 1, 32'h0, "R10 first dump");

        // R4 R8: table sweep, strobe with every sample -> each dump is previous product
        for (int n = 0; n < 10; n++) step(1, 2'b00, 1, 1, 1, 32'h2000_0000, "R4 table sweep");

        // R3: all sample codes, one per window
        for (int c = 0; c < 4; c++) step(1, 2'(c), 1, 1, 1, 32'h2000_0000, "R3 decode");
        step(0, 2'b00, 1, 1, 1, 32'h0, "R3 decode tail");

        // R5: code chips both ways, unforced
        for (int n = 0; n < 12; n++) step(1, 2'(n % 4), n[0], 0, (n % 3) == 0, 32'h1234_5678, "R5 code");
        // R6: forced code ignores chip=0
        for (int n = 0; n < 8; n++) step(1, 2'b11, 0, 1, (n % 4) == 0, 32'h2000_0000, "R6 force");

        // R7 R2: gaps in sample_valid hold phase and sums
        for (int n = 0; n < 16; n++) step(n % 3 != 0, 2'(n), n[1], 0, (n % 8) == 7, 32'h3000_0001, "R7 gaps");
        // R8: strobe without a sample starts window at zero
        step(0, 2'b00, 1, 1, 1, 32'h0, "R8 empty load");
        step(1, 2'b01, 1, 1, 0, 32'h0, "R8 after empty");
        step(0, 2'b00, 1, 1, 1, 32'h0, "R8 dump after empty");
        // R9: hold between dumps
        for (int n = 0; n < 6; n++) step(1, 2'b10, 1, 1, 0, 32'h0100_0000, "R9 hold");

        // R11: full-scale epoch, +3 x cos 2 at phase 0
        apply_reset("R1 reset mid");
        step(0, 2'b00, 1, 1, 1, 32'h0, "R10 realign");
        for (int n = 0; n < 5714; n++) step(1, 2'b01, 1, 1, n == 0, 32'h0, "R11 full scale");
        step(0, 2'b00, 1, 1, 1, 32'h0, "R11 dump");

        // R8: beat run, input near 1.405 MHz, local 100 Hz above
        apply_reset("R1 reset beat");
        fs  = 5.714285e6;
        fin = 1.405e6;
        fw_beat = 32'(longint'((fin + 100.0) / fs * 4294967296.0));
        for (int e = 0; e < 4; e++) begin
            for (int n = 0; n < 5714; n++) begin
                ph = $sin(2.0 * PI * fin * real'(e * 5714 + n) / fs);
                step(1, {ph < 0.0, (ph > 0.5) || (ph < -0.5)}, 1, 1, n == 0, fw_beat, "R8 beat");
            end
        end
        step(0, 2'b00, 1, 1, 1, fw_beat, "R8 beat dump");
        step(0, 2'b00, 1, 1, 0, fw_beat, "R8 pulse end");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule